// File: doc/BRIEF.md
# Posted Write Queue Admission Control

This block sits in front of one posted write queue on the initiator side of a bridge. When a new posted memory write is presented, it decides once whether the write may be accepted or must be answered with a target retry. The decision depends on how many queue entries are free, the cache line size (CLS, in Dwords) of the target bus, a per-queue tuning bit, and whether the write starts on an odd Dword (address bit 2).

The block also maintains the queue's free-entry count. It takes one push strobe per entry written into the queue and one pop strobe per entry drained toward the target bus. The registered decision is held for as long as the request stays asserted, so the bus protocol logic around it sees a stable answer.

Top module: `pwq_admit`

## Requirements
- R1: After reset the free count equals DEPTH. A push alone lowers it by one, a pop alone raises it by one, and a push and a pop in the same cycle leave it unchanged. Each change is visible on `free_cnt` one clock after the strobe.
- R2: The free count never leaves the range 0..DEPTH. A lone push at 0 leaves it at 0, and a lone pop at DEPTH leaves it at DEPTH.
- R3: With `tune_half`=0 and `addr_b2`=0 (even Dword start), the write is accepted exactly when free >= CLS.
- R4: With `tune_half`=0 and `addr_b2`=1 (odd Dword start), the write is accepted exactly when free >= CLS-1. When CLS=0 the threshold is 0.
- R5: With `tune_half`=1 and CLS equal to 8, 16 or 32, the write is accepted exactly when free >= CLS/2, whatever the value of `addr_b2`.
- R6: With `tune_half`=1 and any other CLS, the R3/R4 rules apply unchanged.
- R7: When the free count is 0, a new request always gets retry and never accept, for any CLS or tuning setting.
- R8: The decision is taken on the clock edge where `wr_req` is first seen high and appears on the outputs one clock later. It holds while `wr_req` stays high, even if the free count changes. Both outputs are low one clock after `wr_req` is low. `accept` and `retry` are never high together.
- R9: During and right after reset, `accept` and `retry` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Posted write request, held high for the whole request |
| addr_b2 | input | 1 | Address bit 2 of the first Dword; 1 means odd Dword start |
| tune_half | input | 1 | Queue tuning bit; 1 selects the half-line threshold |
| cls | input | CLS_W | Target-bus cache line size in Dwords |
| push | input | 1 | One entry written into the queue |
| pop | input | 1 | One entry drained from the queue |
| accept | output | 1 | Write accepted for posting |
| retry | output | 1 | Write answered with target retry |
| free_cnt | output | FREE_W | Current free entries, 0..DEPTH |

## Verification
The bench probes each threshold at exactly the threshold and one entry below it. An off-by-one compare, or an odd-start adjustment applied in the wrong mode, flips one of those pairs. It drives the free count to 0 with CLS=0 so that a design with no full-queue override accepts a write it cannot post. It pushes past empty and pops past full, where a design that wraps its counter reports a huge or zero free count. It changes the free count while a request is held, which catches a design that re-evaluates its answer mid-request.

// File: rtl/pwq_admit_pkg.sv
// Package: shared decision encoding and CLS helpers for posted write
// queue admission control.
package pwq_admit_pkg;

    // Registered decision held for the life of one request
    typedef enum logic [1:0] {
        ADM_IDLE   = 2'b00,
        ADM_ACCEPT = 2'b01,
        ADM_RETRY  = 2'b10
    } adm_state_e;

    // True when the cache line size supports the half-line threshold
    function automatic logic cls_half_ok(input logic [7:0] c);
        return (c == 8'd8) || (c == 8'd16) || (c == 8'd32);
    endfunction

endpackage

// File: rtl/pwq_free_tracker.sv
// Module: pwq_free_tracker
// Keeps the count of free queue entries. Push lowers it, pop raises it,
// and both together leave it unchanged.
// Assumes: push/pop are single-cycle strobes, at most one entry each.
// A push at zero or a pop at DEPTH is dropped, so the count is saturated.
module pwq_free_tracker #(
    parameter int DEPTH  = 64,
    parameter int FREE_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic [FREE_W-1:0] free_cnt
);
    localparam logic [FREE_W-1:0] FULL_FREE = FREE_W'(DEPTH);

    logic at_zero;
    logic at_full;
    logic do_dec;
    logic do_inc;

    // Purpose: qualify strobes against the saturation limits
    always_comb begin
        at_zero = (free_cnt == '0);
        at_full = (free_cnt == FULL_FREE);
        do_dec  = push && !pop && !at_zero;
        do_inc  = pop && !push && !at_full;
    end

    // Purpose: update the free count
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_cnt <= FULL_FREE;
        else if (do_dec)
            free_cnt <= free_cnt - 1'b1;
        else if (do_inc)
            free_cnt <= free_cnt + 1'b1;
    end

    // R2
    free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= FULL_FREE);

    // R1
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && free_cnt != '0) |=> free_cnt == $past(free_cnt) - 1'b1);

    // R1
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && free_cnt != FULL_FREE) |=> free_cnt == $past(free_cnt) + 1'b1);

    // R1
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(free_cnt));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && free_cnt == '0) |=> free_cnt == '0);

endmodule

// File: rtl/pwq_threshold.sv
// Module: pwq_threshold
// Works out the minimum free-entry count needed to accept a write.
// Assumes: cls is given in Dwords for the target bus. HALF_EN=0 builds a
// variant without the half-line option, in which the tuning bit is ignored.
module pwq_threshold
    import pwq_admit_pkg::*;
#(
    parameter int CLS_W   = 8,
    parameter bit HALF_EN = 1'b1
) (
    input  logic [CLS_W-1:0] cls,
    input  logic             tune_half,
    input  logic             odd_start,
    output logic [CLS_W-1:0] thr
);
    logic [CLS_W-1:0] line_thr;
    logic [7:0]       cls8;

    // Purpose: narrow or widen cls for the helper function
    always_comb begin
        cls8 = 8'(cls);
    end

    // Purpose: full-line threshold, one less for an odd Dword start
    always_comb begin
        if (odd_start && cls != '0)
            line_thr = cls - 1'b1;
        else
            line_thr = cls;
    end

    generate
        if (HALF_EN) begin : g_half
            // Purpose: pick the half-line threshold for supported sizes
            always_comb begin
                if (tune_half && cls_half_ok(cls8) && (CLS_W >= 6 || cls == CLS_W'(cls8)))
                    thr = cls >> 1;
                else
                    thr = line_thr;
            end
        end else begin : g_line
            // Purpose: full-line threshold only
            always_comb begin
                thr = line_thr;
            end
        end
    endgenerate

endmodule

// File: rtl/pwq_decision.sv
// Module: pwq_decision
// Registers the accept/retry answer on the first cycle of a request and
// holds it until the request drops.
// Assumes: wr_req stays high for the whole request and drops for at least
// one cycle between requests.
module pwq_decision
    import pwq_admit_pkg::*;
#(
    parameter int FREE_W = 7,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic [CLS_W-1:0]  thr,
    output logic              accept,
    output logic              retry
);
    localparam int CMP_W = ((FREE_W > CLS_W) ? FREE_W : CLS_W) + 1;

    adm_state_e state;
    logic       req_q;
    logic       req_new;
    logic       room_ok;

    // Purpose: detect a new request and compare free space to threshold
    always_comb begin
        req_new = wr_req && !req_q;
        room_ok = (free_cnt != '0) && (CMP_W'(free_cnt) >= CMP_W'(thr));
    end

    // Purpose: remember the request level to find its first cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= wr_req;
    end

    // Purpose: take the decision once and hold it during the request
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ADM_IDLE;
        else if (!wr_req)
            state <= ADM_IDLE;
        else if (req_new)
            state <= room_ok ? ADM_ACCEPT : ADM_RETRY;
    end

    // Purpose: drive the outputs from the held decision
    always_comb begin
        accept = (state == ADM_ACCEPT);
        retry  = (state == ADM_RETRY);
    end

    // R7
    full_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_new && free_cnt == '0) |=> retry && !accept);

    // R8
    hold_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_q) |=> $stable(accept) && $stable(retry));

    // R8
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !accept && !retry);

    // R8
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, retry}));

    // R8
    answer_given_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_new |=> (accept || retry));

endmodule

// File: rtl/pwq_admit.sv
// Module: pwq_admit (top)
// Admission control for one posted write queue: tracks free entries and
// answers each new write with accept or retry.
// Assumes: cls is the target-bus cache line size in Dwords. addr_b2 is
// address bit 2 of the first Dword of the write.
module pwq_admit
    import pwq_admit_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int CLS_W   = 8,
    parameter bit HALF_EN = 1'b1,
    parameter int FREE_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              addr_b2,
    input  logic              tune_half,
    input  logic [CLS_W-1:0]  cls,
    input  logic              push,
    input  logic              pop,
    output logic              accept,
    output logic              retry,
    output logic [FREE_W-1:0] free_cnt
);
    logic [CLS_W-1:0] thr;

    pwq_free_tracker #(
        .DEPTH  (DEPTH),
        .FREE_W (FREE_W)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .free_cnt (free_cnt)
    );

    pwq_threshold #(
        .CLS_W   (CLS_W),
        .HALF_EN (HALF_EN)
    ) u_thr (
        .cls       (cls),
        .tune_half (tune_half),
        .odd_start (addr_b2),
        .thr       (thr)
    );

    pwq_decision #(
        .FREE_W (FREE_W),
        .CLS_W  (CLS_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .free_cnt (free_cnt),
        .thr      (thr),
        .accept   (accept),
        .retry    (retry)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !accept && !retry);

endmodule

// File: tb/pwq_admit_test.sv
`timescale 1ns/1ps
module pwq_admit_test;
    localparam int DEPTH  = 64;
    localparam int CLS_W  = 8;
    localparam int FREE_W = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_req = 1'b0;
    logic              addr_b2 = 1'b0;
    logic              tune_half = 1'b0;
    logic [CLS_W-1:0]  cls = '0;
    logic              push = 1'b0;
    logic              pop = 1'b0;
    logic              accept;
    logic              retry;
    logic [FREE_W-1:0] free_cnt;

    int checks = 0;
    int errors = 0;
    int exp_free = DEPTH;

    bit    exp_q[$];
    string tag_q[$];
    logic  prev_req = 1'b0;
    logic  rise_pend = 1'b0;

    always #2 clk = ~clk;

    pwq_admit #(.DEPTH(DEPTH), .CLS_W(CLS_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .addr_b2(addr_b2),
        .tune_half(tune_half), .cls(cls), .push(push), .pop(pop),
        .accept(accept), .retry(retry), .free_cnt(free_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_accept(input int fr, input bit th, input bit odd, input int c);
        int t;
        if (fr == 0) return 1'b0;
        if (th && (c == 8 || c == 16 || c == 32)) t = c / 2;
        else if (odd && c > 0) t = c - 1;
        else t = c;
        return fr >= t;
    endfunction

    // Monitor: note a request's first cycle at the clock edge
    always @(posedge clk) begin
        rise_pend <= wr_req && !prev_req && rst_n;
        prev_req  <= wr_req && rst_n;
    end

    // Monitor: compare the decision one cycle later with the scoreboard
    always @(negedge clk) begin
        if (rise_pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected decision", {accept, retry}, 0);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(accept == e && retry == !e, t, {accept, retry}, {e, !e});
            end
        end
    end

    task automatic set_free(input int n, input string tag);
        while (exp_free > n) begin
            push = 1'b1; @(negedge clk); exp_free--;
        end
        while (exp_free < n) begin
            pop = 1'b1; @(negedge clk); exp_free++;
        end
        push = 1'b0; pop = 1'b0;
        @(negedge clk);
        check(free_cnt == FREE_W'(n), tag, free_cnt, n);
    endtask

    // Driver: issue one request and load the expected answer
    task automatic issue(input bit th, input bit odd, input int c, input string tag);
        tune_half = th; addr_b2 = odd; cls = CLS_W'(c);
        exp_q.push_back(model_accept(exp_free, th, odd, c));
        tag_q.push_back(tag);
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
        check(!accept && !retry, "R8 drop clears", {accept, retry}, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!accept && !retry, "R9 outputs low in reset", {accept, retry}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!accept && !retry, "R9 outputs low after reset", {accept, retry}, 0);
        check(free_cnt == FREE_W'(DEPTH), "R1 reset free", free_cnt, DEPTH);

        // R3 even start, full line
        set_free(16, "R1 set 16");
        issue(0, 0, 16, "R3 free=CLS accept");
        set_free(15, "R1 set 15");
        issue(0, 0, 16, "R3 free=CLS-1 retry");
        // R4 odd start
        issue(0, 1, 16, "R4 free=CLS-1 accept");
        set_free(14, "R1 set 14");
        issue(0, 1, 16, "R4 free=CLS-2 retry");

        // R5 half-line
        set_free(8, "R1 set 8");
        issue(1, 0, 16, "R5 cls16 free 8 accept");
        set_free(7, "R1 set 7");
        issue(1, 1, 16, "R5 cls16 free 7 retry");
        issue(1, 0, 8, "R5 cls8 free 7 accept");
        set_free(3, "R1 set 3");
        issue(1, 1, 8, "R5 cls8 free 3 retry");
        set_free(16, "R1 set 16b");
        issue(1, 1, 32, "R5 cls32 free 16 accept");
        set_free(15, "R1 set 15b");
        issue(1, 0, 32, "R5 cls32 free 15 retry");

        // R6 unsupported size falls back
        set_free(11, "R1 set 11");
        issue(1, 1, 12, "R6 cls12 odd free 11 accept");
        issue(1, 0, 12, "R6 cls12 even free 11 retry");

        // R1 simultaneous push and pop
        set_free(10, "R1 set 10");
        push = 1'b1; pop = 1'b1; @(negedge clk);
        push = 1'b0; pop = 1'b0; @(negedge clk);
        check(free_cnt == 10, "R1 push+pop unchanged", free_cnt, 10);

        // R2 saturation at empty, then R7 full queue
        set_free(0, "R1 set 0");
        push = 1'b1; @(negedge clk); push = 1'b0; @(negedge clk);
        check(free_cnt == 0, "R2 no underflow", free_cnt, 0);
        issue(0, 0, 0, "R7 full queue cls0 retry");
        issue(1, 1, 0, "R7 full queue odd retry");
        issue(1, 0, 8, "R7 full queue half retry");
        set_free(1, "R1 set 1");
        issue(0, 1, 0, "R4 cls0 odd free 1 accept");

        // R2 saturation at DEPTH
        set_free(DEPTH, "R1 set depth");
        pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
        check(free_cnt == FREE_W'(DEPTH), "R2 no overflow", free_cnt, DEPTH);

        // R8 held decision while free count drops below threshold
        tune_half = 1'b0; addr_b2 = 1'b0; cls = CLS_W'(32);
        exp_q.push_back(1'b1); tag_q.push_back("R8 held request accept");
        wr_req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            push = 1'b1; @(negedge clk); exp_free--;
        end
        push = 1'b0;
        @(negedge clk);
        check(accept && !retry, "R8 decision held", {accept, retry}, 2);
        wr_req = 1'b0;
        @(negedge clk);
        check(!accept && !retry, "R8 drop after hold", {accept, retry}, 0);
        issue(0, 0, 32, "R8 new request sees new free");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8 all decisions seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule